// File: doc/BRIEF.md
# Normalizing Barrel Shifter Unit

This unit shifts and rescales 16-bit fixed-point words for block floating-point and multiword arithmetic. A 16-bit operand is placed in the upper half of a 32-bit result field, bits 31:16, with the lower half zero. It is then shifted by a signed amount: a positive amount moves it toward the MSB and a negative amount moves it toward the LSB. Logical and arithmetic right shifts differ in the bit that fills the vacated positions. Because the field has 32 bits, the bits shifted out of the upper half remain in the lower half, which lets a wide value be shifted one 16-bit word at a time.

The unit also counts the redundant sign bits of the operand and reports that count, negated, as an exponent. Normalize shifts these redundant bits out. Denormalize shifts right by a given exponent, which undoes a normalize or aligns a word to a common block scale. A block-exponent register holds the smallest exponent derived since it was last cleared. Software can therefore run derive-exponent over a whole buffer and then scale every word by one common amount.

All results are registered with a latency of one clock. An output that the current operation does not produce keeps its previous value.

Top module: `nbs_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result_o`, `exp_o` and `blk_exp_o` are cleared to 0.
- R2: With op code 1 (logical shift), the cycle after the edge `result_o` equals `{operand_i,16'h0}` shifted by `amount_i`. The amount is signed, from -32 to 31. A positive amount shifts left and a negative amount shifts right, and zeros fill the vacated bits in both directions.
- R3: With op code 2 (arithmetic shift), left shifts behave as in R2. Right shifts fill the vacated bits with `operand_i[15]`.
- R4: At the extremes of the shift range, an amount of -32 gives all fill bits: zero for a logical shift and copies of `operand_i[15]` for an arithmetic shift. In a left shift, bits pushed past bit 31 are lost.
- R5: With op code 5 (derive exponent), `exp_o` becomes minus the count of bits below bit 15 that match bit 15 without a break, so its value lies between -15 and 0. An operand of 16'h0000 or 16'hFFFF gives -15.
- R6: With op code 3 (normalize), `result_o` becomes `{operand_i,16'h0}` shifted left by the redundant-sign count of R5, and `exp_o` is loaded with the same exponent as in R5.
- R7: With op code 4 (denormalize), `amount_i` is taken as an exponent e. For e ≤ 0, `result_o` becomes `{operand_i,16'h0}` shifted arithmetically right by -e. For e > 0 no shift is applied.
- R8: On each derive-exponent operation, `blk_exp_o` takes the minimum of its current value and the new exponent. `blk_clr_i` restarts the block: alone it sets `blk_exp_o` to 0, and together with a derive-exponent operation it loads that operation's exponent. Operations other than derive exponent leave `blk_exp_o` unchanged.
- R9: `result_o` holds its value under op codes 0, 5, 6 and 7. `exp_o` holds its value under op codes 0, 1, 2, 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 logical shift, 2 arithmetic shift, 3 normalize, 4 denormalize, 5 derive exponent |
| operand_i | input | 16 | Data word |
| amount_i | input | 6 | Signed shift amount, or the exponent for denormalize |
| blk_clr_i | input | 1 | Restart block-exponent tracking |
| result_o | output | 32 | Registered 32-bit shift result |
| exp_o | output | 5 | Registered derived exponent, two's complement |
| blk_exp_o | output | 5 | Minimum exponent since the last clear, two's complement |

## Verification
The exponent logic is swept with single-one words at every bit position and with their complements. The single-one words show that a positive run is counted correctly, and the complements show that a negative run is counted correctly. The all-zero and all-ones words confirm that the count saturates at 15.

The shifts use the operand 16'h8001, which sets both end bits. Applying it in both directions and at the amounts 0, -32, 15 and 31 separates the zero fill from the sign fill and exposes any off-by-one in the distance. Denormalize is tried with positive and negative words and with a positive exponent.

The block tracker is fed a sequence of exponents that falls and then rises, and normalize operations are placed in between. This shows that the register keeps the minimum, ignores every operation other than derive exponent, and restarts correctly when a clear coincides with a derive.

// File: rtl/nbs_pkg.sv
// Package nbs_pkg
// Shared operation codes and widths for the normalizing barrel shifter.
// Assumes a 3-bit operation field; codes 6 and 7 are treated as no-op.
package nbs_pkg;
    localparam int DATA_W = 16;
    localparam int FIELD_W = 2 * DATA_W;
    localparam int AMT_W = $clog2(FIELD_W) + 1;
    localparam int CNT_W = $clog2(DATA_W);
    localparam int EXP_W = CNT_W + 1;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LSH    = 3'd1,
        OP_ASH    = 3'd2,
        OP_NORM   = 3'd3,
        OP_DENORM = 3'd4,
        OP_EXP    = 3'd5
    } nbs_op_e;
endpackage

// File: rtl/nbs_expdet.sv
// Module nbs_expdet
// Counts the bits below the MSB that equal the MSB without a break
// (redundant sign bits) and gives the negated count as an exponent.
// Assumes DW >= 2. Purely combinational. An all-zero or all-ones word
// gives the maximum count, DW-1.
module nbs_expdet #(
    parameter int DW = 16,
    localparam int CW = $clog2(DW),
    localparam int EW = CW + 1
) (
    input  logic [DW-1:0]        data_i,
    output logic [CW-1:0]        count_o,
    output logic signed [EW-1:0] exp_o
);
    logic run;

    // Walk down from the bit below the MSB while bits match the sign.
    always_comb begin
        count_o = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (data_i[i] == data_i[DW-1])) begin
                count_o = count_o + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

    // Exponent is the count negated in two's complement.
    always_comb begin
        exp_o = -$signed({1'b0, count_o});
    end
endmodule

// File: rtl/nbs_barrel.sv
// Module nbs_barrel
// Logarithmic barrel shifter over a W-bit field. It shifts left with zero
// fill, or right with fill_i. A distance of W or more yields all fill bits.
// Assumes AW is wide enough to hold W. Purely combinational.
module nbs_barrel #(
    parameter int W = 32,
    parameter int AW = 6
) (
    input  logic [W-1:0]  data_i,
    input  logic          left_i,
    input  logic [AW-1:0] dist_i,
    input  logic          fill_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] lch [0:AW];
    logic [W-1:0] rch [0:AW];

    assign lch[0] = data_i;
    assign rch[0] = data_i;

    // One stage per distance bit; stages at or beyond W clear the field.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        if (SH < W) begin : g_part
            assign lch[k+1] = dist_i[k] ? {lch[k][W-1-SH:0], {SH{1'b0}}} : lch[k];
            assign rch[k+1] = dist_i[k] ? {{SH{fill_i}}, rch[k][W-1:SH]} : rch[k];
        end else begin : g_full
            assign lch[k+1] = dist_i[k] ? '0 : lch[k];
            assign rch[k+1] = dist_i[k] ? {W{fill_i}} : rch[k];
        end
    end

    // Pick the direction requested.
    assign data_o = left_i ? lch[AW] : rch[AW];
endmodule

// File: rtl/nbs_blkexp.sv
// Module nbs_blkexp
// Block-exponent tracker: keeps the smallest exponent presented with upd_i
// since the last clear. Clear alone loads 0 (the largest possible
// exponent); clear together with an update loads the new exponent.
// Assumes exponents are two's complement and never positive.
module nbs_blkexp #(
    parameter int EW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 upd_i,
    input  logic signed [EW-1:0] exp_i,
    output logic signed [EW-1:0] blk_o
);
    // Register the running minimum, restarted by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_o <= '0;
        end else if (clr_i) begin
            blk_o <= upd_i ? exp_i : '0;
        end else if (upd_i && (exp_i < blk_o)) begin
            blk_o <= exp_i;
        end
    end

    // R8: without a clear the tracked value never increases.
    a_r8_blk_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (blk_o <= $past(blk_o)));

    // R8: after an update the tracked value is no larger than that exponent.
    a_r8_blk_le_new: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (blk_o <= $past(exp_i)));

    // R8: a clear without an update restarts at zero.
    a_r8_blk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !upd_i) |=> (blk_o == '0));
endmodule

// File: rtl/nbs_unit.sv
// Module nbs_unit
// Normalizing barrel shifter top level. The operand is placed at the top of
// a 32-bit field and shifted by a signed amount, normalized by its
// redundant-sign count, or denormalized by an exponent. The derived and
// block exponents are registered alongside. Latency is one clock.
// Assumes operation decode happens upstream; unused codes act as no-op.
module nbs_unit
    import nbs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              op_i,
    input  logic [DATA_W-1:0]       operand_i,
    input  logic signed [AMT_W-1:0] amount_i,
    input  logic                    blk_clr_i,
    output logic [FIELD_W-1:0]      result_o,
    output logic signed [EXP_W-1:0] exp_o,
    output logic signed [EXP_W-1:0] blk_exp_o
);
    logic [CNT_W-1:0]        rs_count;
    logic signed [EXP_W-1:0] rs_exp;
    logic [FIELD_W-1:0]      field;
    logic [FIELD_W-1:0]      shifted;
    logic                    sh_left;
    logic [AMT_W-1:0]        sh_dist;
    logic                    sh_fill;
    logic [AMT_W-1:0]        amt_mag;
    logic                    amt_neg;
    logic                    load_res;
    logic                    load_exp;
    logic                    is_exp;

    assign field = {operand_i, {DATA_W{1'b0}}};

    nbs_expdet #(.DW(DATA_W)) u_expdet (
        .data_i  (operand_i),
        .count_o (rs_count),
        .exp_o   (rs_exp)
    );

    // Split the signed amount into direction and magnitude.
    always_comb begin
        amt_neg = amount_i[AMT_W-1];
        amt_mag = amt_neg ? AMT_W'(-amount_i) : AMT_W'(amount_i);
    end

    // Choose the shifter controls and the output load enables per operation.
    always_comb begin
        sh_left = 1'b1;
        sh_dist = '0;
        sh_fill = 1'b0;
        load_res = 1'b0;
        load_exp = 1'b0;
        is_exp = 1'b0;
        case (op_i)
            OP_LSH: begin
                sh_left = !amt_neg;
                sh_dist = amt_mag;
                load_res = 1'b1;
            end
            OP_ASH: begin
                sh_left = !amt_neg;
                sh_dist = amt_mag;
                sh_fill = operand_i[DATA_W-1];
                load_res = 1'b1;
            end
            OP_NORM: begin
                sh_dist = AMT_W'(rs_count);
                load_res = 1'b1;
                load_exp = 1'b1;
            end
            OP_DENORM: begin
                sh_left = 1'b0;
                sh_dist = amt_neg ? amt_mag : '0;
                sh_fill = operand_i[DATA_W-1];
                load_res = 1'b1;
            end
            OP_EXP: begin
                load_exp = 1'b1;
                is_exp = 1'b1;
            end
            default: begin
                load_res = 1'b0;
            end
        endcase
    end

    nbs_barrel #(.W(FIELD_W), .AW(AMT_W)) u_barrel (
        .data_i (field),
        .left_i (sh_left),
        .dist_i (sh_dist),
        .fill_i (sh_fill),
        .data_o (shifted)
    );

    // Register the shift result when the operation produces one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (load_res) begin
            result_o <= shifted;
        end
    end

    // Register the derived exponent when the operation produces one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_o <= '0;
        end else if (load_exp) begin
            exp_o <= rs_exp;
        end
    end

    nbs_blkexp #(.EW(EXP_W)) u_blkexp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (blk_clr_i),
        .upd_i (is_exp),
        .exp_i (rs_exp),
        .blk_o (blk_exp_o)
    );

    // R9: operations without a shift result keep result_o.
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i == OP_EXP || op_i > OP_EXP) |=> $stable(result_o));

    // R9: plain shifts and denormalize keep exp_o.
    a_r9_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LSH || op_i == OP_ASH || op_i == OP_DENORM) |=> $stable(exp_o));

    // R5: the derived exponent stays within -15..0.
    a_r5_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_o <= 0) && (exp_o >= -$signed(EXP_W'(DATA_W - 1))));

    // R6: a normalized non-trivial word has differing top two bits.
    a_r6_norm_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NORM && operand_i != '0 && operand_i != '1)
        |=> (result_o[FIELD_W-1] != result_o[FIELD_W-2]));

    // R3: an arithmetic right shift leaves the sign in the top bit.
    a_r3_ash_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ASH && amount_i < 0)
        |=> (result_o[FIELD_W-1] == $past(operand_i[DATA_W-1])));

    // R2: a logical right shift always clears the top bit.
    a_r2_lsh_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LSH && amount_i < 0) |=> (result_o[FIELD_W-1] == 1'b0));
endmodule

// File: tb/nbs_unit_tb_top.sv
// Directed bench for nbs_unit: one task per scenario, each checking itself.
module nbs_unit_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op = 3'd0;
    logic [15:0]       operand = 16'h0;
    logic signed [5:0] amount = 6'sd0;
    logic              blk_clr = 1'b0;
    logic [31:0]       result;
    logic signed [4:0] expv;
    logic signed [4:0] blkv;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nbs_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .operand_i (operand),
        .amount_i  (amount),
        .blk_clr_i (blk_clr),
        .result_o  (result),
        .exp_o     (expv),
        .blk_exp_o (blkv)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    function automatic logic [31:0] sx(input logic signed [4:0] v);
        return {{27{v[4]}}, v};
    endfunction

    // Apply one operation for one edge; outputs are read at the next negedge.
    task automatic run_op(input logic [2:0] o, input logic [15:0] d,
                          input int a, input logic c);
        @(negedge clk);
        op = o; operand = d; amount = 6'(a); blk_clr = c;
        @(negedge clk);
        op = 3'd0; blk_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        run_op(3'd1, 16'hFFFF, 4, 1'b0);
        check("R1 result under reset", result, 32'h0);
        check("R1 exp under reset", sx(expv), 32'h0);
        check("R1 blk under reset", sx(blkv), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_logical();
        run_op(3'd1, 16'h8001, -4, 1'b0);
        check("R2 lsh right 4", result, 32'h0800_1000);
        run_op(3'd1, 16'h8001, 4, 1'b0);
        check("R2 lsh left 4", result, 32'h0010_0000);
        run_op(3'd1, 16'h8001, 0, 1'b0);
        check("R2 lsh zero", result, 32'h8001_0000);
        run_op(3'd1, 16'h1234, -16, 1'b0);
        check("R2 lsh right 16", result, 32'h0000_1234);
    endtask

    task automatic t_arith();
        run_op(3'd2, 16'h8001, -4, 1'b0);
        check("R3 ash right 4 negative", result, 32'hF800_1000);
        run_op(3'd2, 16'h4001, -4, 1'b0);
        check("R3 ash right 4 positive", result, 32'h0400_1000);
        run_op(3'd2, 16'h8001, 4, 1'b0);
        check("R3 ash left 4", result, 32'h0010_0000);
    endtask

    task automatic t_limits();
        run_op(3'd2, 16'h8001, -32, 1'b0);
        check("R4 ash right 32", result, 32'hFFFF_FFFF);
        run_op(3'd1, 16'h8001, -32, 1'b0);
        check("R4 lsh right 32", result, 32'h0);
        run_op(3'd1, 16'h0001, 15, 1'b0);
        check("R4 lsh left 15", result, 32'h8000_0000);
        run_op(3'd1, 16'h0001, 31, 1'b0);
        check("R4 lsh left 31 drops", result, 32'h0);
        run_op(3'd2, 16'h8001, -31, 1'b0);
        check("R4 ash right 31", result, 32'hFFFF_FFFF);
    endtask

    task automatic t_exponent();
        for (int k = 0; k < 15; k++) begin
            run_op(3'd5, 16'(1 << k), 0, 1'b0);
            check($sformatf("R5 exp one-hot bit %0d", k), sx(expv), 32'(k - 14));
            run_op(3'd5, ~16'(1 << k), 0, 1'b0);
            check($sformatf("R5 exp inverted bit %0d", k), sx(expv), 32'(k - 14));
        end
        run_op(3'd5, 16'h0000, 0, 1'b0);
        check("R5 exp zero", sx(expv), 32'(-15));
        run_op(3'd5, 16'hFFFF, 0, 1'b0);
        check("R5 exp ones", sx(expv), 32'(-15));
        run_op(3'd5, 16'h8000, 0, 1'b0);
        check("R5 exp 8000", sx(expv), 32'h0);
    endtask

    task automatic t_normalize();
        run_op(3'd3, 16'h0001, 0, 1'b0);
        check("R6 norm 0001", result, 32'h4000_0000);
        check("R6 norm exp 0001", sx(expv), 32'(-14));
        run_op(3'd3, 16'hFFFF, 0, 1'b0);
        check("R6 norm FFFF", result, 32'h8000_0000);
        run_op(3'd3, 16'hF123, 0, 1'b0);
        check("R6 norm F123", result, 32'h8918_0000);
        check("R6 norm exp F123", sx(expv), 32'(-3));
        run_op(3'd3, 16'h0000, 0, 1'b0);
        check("R6 norm zero", result, 32'h0);
    endtask

    task automatic t_denorm();
        run_op(3'd4, 16'h7FFF, -3, 1'b0);
        check("R7 denorm 7FFF by 3", result, 32'h0FFF_E000);
        run_op(3'd4, 16'h8000, -1, 1'b0);
        check("R7 denorm 8000 by 1", result, 32'hC000_0000);
        run_op(3'd4, 16'h8000, 5, 1'b0);
        check("R7 denorm positive exponent", result, 32'h8000_0000);
    endtask

    task automatic t_block();
        run_op(3'd0, 16'h0, 0, 1'b1);
        check("R8 clear alone", sx(blkv), 32'h0);
        run_op(3'd5, 16'h4000, 0, 1'b0);
        check("R8 exp 0", sx(blkv), 32'h0);
        run_op(3'd5, 16'h0100, 0, 1'b0);
        check("R8 min -6", sx(blkv), 32'(-6));
        run_op(3'd5, 16'h1000, 0, 1'b0);
        check("R8 keep -6 after -2", sx(blkv), 32'(-6));
        run_op(3'd3, 16'h0000, 0, 1'b0);
        check("R8 normalize ignored", sx(blkv), 32'(-6));
        run_op(3'd5, 16'h0000, 0, 1'b0);
        check("R8 min -15", sx(blkv), 32'(-15));
        run_op(3'd5, 16'h2000, 0, 1'b1);
        check("R8 clear with exp", sx(blkv), 32'(-1));
        run_op(3'd3, 16'h0001, 0, 1'b0);
        check("R8 normalize ignored again", sx(blkv), 32'(-1));
        run_op(3'd0, 16'h0, 0, 1'b1);
        check("R8 clear to zero", sx(blkv), 32'h0);
    endtask

    task automatic t_hold();
        run_op(3'd1, 16'hABCD, 0, 1'b0);
        check("R9 setup result", result, 32'hABCD_0000);
        run_op(3'd0, 16'h1111, 3, 1'b0);
        check("R9 nop holds result", result, 32'hABCD_0000);
        run_op(3'd6, 16'h2222, -2, 1'b0);
        check("R9 code 6 holds result", result, 32'hABCD_0000);
        run_op(3'd7, 16'h3333, 1, 1'b0);
        check("R9 code 7 holds result", result, 32'hABCD_0000);
        run_op(3'd5, 16'h0010, 2, 1'b0);
        check("R9 exp op holds result", result, 32'hABCD_0000);
        check("R9 exp op sets exp", sx(expv), 32'(-10));
        run_op(3'd1, 16'h0000, 1, 1'b0);
        check("R9 shift holds exp", sx(expv), 32'(-10));
        run_op(3'd4, 16'h0000, -1, 1'b0);
        check("R9 denorm holds exp", sx(expv), 32'(-10));
        run_op(3'd7, 16'h0000, 0, 1'b0);
        check("R9 code 7 holds exp", sx(expv), 32'(-10));
    endtask

    initial begin
        t_reset();
        t_logical();
        t_arith();
        t_limits();
        t_exponent();
        t_normalize();
        t_denorm();
        t_block();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule